// File: doc/BRIEF.md
# UART Receive/Transmit Data Register Pair

This block sits between a processor bus and the serial engine of a UART. The receive holding register and the transmit holding register share one bus location. A bus read returns the receive holding register, and a bus write loads the transmit holding register. The bus never sees the transmit byte, and a write never alters what a read returns.

A completed frame arrives from the receive shift logic as a byte with a completion pulse and two per-frame error indications (parity and framing). The block latches the byte, sets a receive-full flag and can raise an interrupt request. It detects overrun itself. It also supports a short-word mode in which the top data bit is stored as zero. A break indication from an external detector empties the holding register. On the transmit side a written byte is presented to the transmit shifter with a one-cycle load pulse, and an empty flag tracks whether the shifter has taken the byte.

Top module: `uart_dreg_if`

## Requirements
- R1: After a synchronous reset, `bus_rdata` is 0x00, `tx_data` is 0xFF, `rx_full`, `rx_irq`, `ovr_err` and `tx_load` are 0, and `tx_empty` is 1.
- R2: A cycle with `rx_done`=1 and `rx_full`=0 latches `rx_byte` into the receive holding register and sets `rx_full` at the following clock edge.
- R3: While `short_word`=1, a latched frame has bit 7 (the top data bit) stored as 0. The lower bits are kept unchanged.
- R4: `rx_irq` is set by a frame completion only when `rx_irq_en`=1. With `rx_irq_en`=0 a completion leaves `rx_irq` at 0.
- R5: A bus read (`bus_rd`=1) with no frame completion in the same cycle clears `rx_full`.
- R6: A bus read clears `rx_irq` only when no error flag (parity, framing, overrun) is held. `err_clr`=1 clears all held error flags and `rx_irq`.
- R7: `brk_det`=1 clears `rx_full` and leaves the holding register unchanged.
- R8: `rx_valid_data` equals the holding register when no error flag is held, and is 0x00 while any of parity, framing or overrun is held.
- R9: A frame completion while `rx_full`=1 and no read in the same cycle sets `ovr_err`, keeps the previous byte and keeps `rx_full` at 1.
- R10: When a read and a frame completion fall in the same cycle, the completion wins. `rx_full` stays 1, the new byte is latched and no overrun is flagged.
- R11: A bus write loads `bus_wdata` into `tx_data`, drives `tx_load` high for exactly the next cycle, and clears `tx_empty`.
- R12: `tx_accept`=1 sets `tx_empty`. If a write occurs in the same cycle, `tx_empty` becomes 0.
- R13: A bus write does not change `bus_rdata`, because both registers share one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for the shared data location |
| bus_wr | input | 1 | Write strobe for the shared data location |
| bus_wdata | input | 8 | Write data for the transmit register |
| bus_rdata | output | 8 | Receive holding register |
| short_word | input | 1 | 1 = 7-bit data, top bit stored as 0 |
| rx_done | input | 1 | Frame completion pulse from the receive shifter |
| rx_byte | input | 8 | Assembled frame data |
| rx_par_err | input | 1 | Parity error of the completing frame |
| rx_frm_err | input | 1 | Framing error of the completing frame |
| brk_det | input | 1 | Break detected, empties the holding register |
| rx_irq_en | input | 1 | Receive interrupt enable |
| err_clr | input | 1 | Clears held error flags and the interrupt |
| rx_full | output | 1 | Receive holding register full |
| rx_irq | output | 1 | Receive interrupt request |
| ovr_err | output | 1 | Overrun error held |
| rx_valid_data | output | 8 | Received byte, 0x00 while an error is held |
| tx_data | output | 8 | Transmit holding register toward the shifter |
| tx_load | output | 1 | One-cycle load pulse toward the shifter |
| tx_empty | output | 1 | Transmit register free |
| tx_accept | input | 1 | Shifter has taken the transmit byte |

## Verification
Frames are fed with all-ones data in both word modes, so that the masking of the top bit is seen on its own. Clean frames are run against frames carrying parity or framing errors, and these show whether the interrupt is held on a read and whether the valid-data output is zeroed. Back-to-back completions, with no read and then with a read in the same cycle, separate an overrun from the completion-wins priority. A break after a frame, and writes with and without a simultaneous shifter accept, exercise the flag-clearing paths and the transmit handshake.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;
  typedef struct packed {
    logic par;
    logic frm;
    logic ovr;
  } rx_err_t;

  function automatic logic err_any(rx_err_t e);
    return e.par | e.frm | e.ovr;
  endfunction
endpackage

// File: rtl/uart_dreg_rx.sv
module uart_dreg_rx
  import uart_dreg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] RX_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          short_word,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          brk_det,
  input  logic          irq_en,
  input  logic          rd,
  input  logic          err_clr,
  output logic [DW-1:0] hold,
  output logic          full,
  output logic          irq,
  output rx_err_t       err
);
  localparam int TOP = DW - 1;

  logic [DW-1:0] masked;
  logic          overrun;

  generate
    if (DW > 1) begin : g_mask
      always_comb begin
        masked = rx_byte;
        if (short_word) masked[TOP] = 1'b0;
      end
    end else begin : g_nomask
      always_comb masked = rx_byte;
    end
  endgenerate

  // a read in the same cycle consumes the old byte, so no overrun
  assign overrun = rx_done && full && !rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= RX_INIT;
      full <= 1'b0;
      irq  <= 1'b0;
      err  <= '0;
    end else begin
      if (err_clr) begin
        err <= '0;
        irq <= 1'b0;
      end
      if (rd && !err_any(err)) irq <= 1'b0;
      if (rd || brk_det) full <= 1'b0;
      if (rx_done) begin
        full <= 1'b1;
        if (irq_en) irq <= 1'b1;
        if (overrun) begin
          err.ovr <= 1'b1;
        end else begin
          hold    <= masked;
          err.par <= rx_par_err;
          err.frm <= rx_frm_err;
        end
      end
    end
  end

  // R2
  full_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> full);
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !rx_done) |=> !full);
  // R7
  brk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_det && !rx_done) |=> (!full && $stable(hold)));
  // R9
  overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && full && !rd) |=> (err.ovr && $stable(hold)));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && err_any(err) && !err_clr && !rx_done) |=> (irq == $past(irq)));
  // R3
  short_top_chk: assert property (@(posedge clk) disable iff (rst)
    (short_word && rx_done && !(full && !rd)) |=> !hold[TOP]);
  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && !irq_en) |=> !irq);
endmodule

// File: rtl/uart_dreg_tx.sv
module uart_dreg_tx #(
  parameter int DW = 8,
  parameter logic [DW-1:0] TX_INIT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          accept,
  output logic [DW-1:0] data,
  output logic          load,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= TX_INIT;
      load  <= 1'b0;
      empty <= 1'b1;
    end else begin
      load <= wr;
      if (accept) empty <= 1'b1;
      if (wr) begin
        data  <= wdata;
        empty <= 1'b0;
      end
    end
  end

  // R11
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (load && !empty));
  // R11
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> !load);
  // R12
  accept_set_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !wr) |=> empty);
endmodule

// File: rtl/uart_dreg_if.sv
module uart_dreg_if
  import uart_dreg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] RX_INIT = '0,
  parameter logic [DW-1:0] TX_INIT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          short_word,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          brk_det,
  input  logic          rx_irq_en,
  input  logic          err_clr,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          ovr_err,
  output logic [DW-1:0] rx_valid_data,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  output logic          tx_empty,
  input  logic          tx_accept
);
  logic [DW-1:0] hold;
  rx_err_t       err;

  uart_dreg_rx #(.DW(DW), .RX_INIT(RX_INIT)) u_rx (
    .clk(clk), .rst(rst), .short_word(short_word), .rx_done(rx_done),
    .rx_byte(rx_byte), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .brk_det(brk_det), .irq_en(rx_irq_en), .rd(bus_rd), .err_clr(err_clr),
    .hold(hold), .full(rx_full), .irq(rx_irq), .err(err)
  );

  uart_dreg_tx #(.DW(DW), .TX_INIT(TX_INIT)) u_tx (
    .clk(clk), .rst(rst), .wr(bus_wr), .wdata(bus_wdata),
    .accept(tx_accept), .data(tx_data), .load(tx_load), .empty(tx_empty)
  );

  assign bus_rdata     = hold;
  assign ovr_err       = err.ovr;
  assign rx_valid_data = err_any(err) ? '0 : hold;

  // R13
  shared_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !rx_done) |=> $stable(bus_rdata));
endmodule

// File: tb/uart_dreg_if_test.sv
module uart_dreg_if_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 0, bus_wr = 0, short_word = 0, rx_done = 0;
  logic       rx_par_err = 0, rx_frm_err = 0, brk_det = 0, rx_irq_en = 0;
  logic       err_clr = 0, tx_accept = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 0;
  logic [7:0] bus_rdata, rx_valid_data, tx_data;
  logic       rx_full, rx_irq, ovr_err, tx_load, tx_empty;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  uart_dreg_if uut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .short_word(short_word),
    .rx_done(rx_done), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .brk_det(brk_det), .rx_irq_en(rx_irq_en),
    .err_clr(err_clr), .rx_full(rx_full), .rx_irq(rx_irq), .ovr_err(ovr_err),
    .rx_valid_data(rx_valid_data), .tx_data(tx_data), .tx_load(tx_load),
    .tx_empty(tx_empty), .tx_accept(tx_accept)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic frame(logic [7:0] b, logic par, logic frm, logic rd);
    rx_byte = b; rx_par_err = par; rx_frm_err = frm; rx_done = 1; bus_rd = rd;
    tick();
    rx_done = 0; rx_par_err = 0; rx_frm_err = 0; bus_rd = 0;
  endtask

  task automatic do_read();
    bus_rd = 1; tick(); bus_rd = 0;
  endtask

  task automatic do_clr();
    err_clr = 1; tick(); err_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "rdata", bus_rdata, 8'h00);
    chk("R1", "tx_data", tx_data, 8'hFF);
    chk("R1", "full", rx_full, 0);
    chk("R1", "irq", rx_irq, 0);
    chk("R1", "ovr", ovr_err, 0);
    chk("R1", "tx_load", tx_load, 0);
    chk("R1", "tx_empty", tx_empty, 1);
  endtask

  task automatic t_clean();
    rx_irq_en = 1;
    frame(8'hA5, 0, 0, 0);
    chk("R2", "full", rx_full, 1);
    chk("R2", "rdata", bus_rdata, 8'hA5);
    chk("R8", "valid", rx_valid_data, 8'hA5);
    chk("R4", "irq on", rx_irq, 1);
    do_read();
    chk("R5", "full after read", rx_full, 0);
    chk("R6", "irq cleared by clean read", rx_irq, 0);
    rx_irq_en = 0;
    frame(8'h3C, 0, 0, 0);
    chk("R4", "irq disabled", rx_irq, 0);
    chk("R2", "rdata 3C", bus_rdata, 8'h3C);
    do_read();
  endtask

  task automatic t_short();
    short_word = 1;
    frame(8'hFF, 0, 0, 0);
    chk("R3", "short word", bus_rdata, 8'h7F);
    do_read();
    short_word = 0;
    frame(8'hFF, 0, 0, 0);
    chk("R3", "full word", bus_rdata, 8'hFF);
    do_read();
  endtask

  task automatic t_errors();
    rx_irq_en = 1;
    frame(8'h55, 1, 0, 0);
    chk("R8", "valid zero on parity", rx_valid_data, 8'h00);
    chk("R8", "rdata kept", bus_rdata, 8'h55);
    do_read();
    chk("R5", "full after read", rx_full, 0);
    chk("R6", "irq held on error", rx_irq, 1);
    do_clr();
    chk("R6", "irq cleared by err_clr", rx_irq, 0);
    chk("R8", "valid after clear", rx_valid_data, 8'h55);
    frame(8'h66, 0, 1, 0);
    chk("R8", "valid zero on framing", rx_valid_data, 8'h00);
    do_read();
    chk("R6", "irq held on framing", rx_irq, 1);
    do_clr();
    rx_irq_en = 0;
  endtask

  task automatic t_break();
    frame(8'h12, 0, 0, 0);
    brk_det = 1; tick(); brk_det = 0;
    chk("R7", "full after break", rx_full, 0);
    chk("R7", "byte kept", bus_rdata, 8'h12);
  endtask

  task automatic t_overrun();
    frame(8'h11, 0, 0, 0);
    frame(8'h22, 0, 0, 0);
    chk("R9", "ovr", ovr_err, 1);
    chk("R9", "old byte", bus_rdata, 8'h11);
    chk("R9", "full", rx_full, 1);
    chk("R8", "valid zero on overrun", rx_valid_data, 8'h00);
    do_read();
    do_clr();
    chk("R6", "ovr cleared", ovr_err, 0);
  endtask

  task automatic t_collide();
    frame(8'h33, 0, 0, 0);
    frame(8'h44, 0, 0, 1);
    chk("R10", "full kept", rx_full, 1);
    chk("R10", "new byte", bus_rdata, 8'h44);
    chk("R10", "no overrun", ovr_err, 0);
    do_read();
  endtask

  task automatic t_tx();
    bus_wdata = 8'h5A; bus_wr = 1; tick(); bus_wr = 0;
    chk("R11", "tx_data", tx_data, 8'h5A);
    chk("R11", "load high", tx_load, 1);
    chk("R11", "empty low", tx_empty, 0);
    chk("R13", "rdata unchanged", bus_rdata, 8'h44);
    tick();
    chk("R11", "load one cycle", tx_load, 0);
    tx_accept = 1; tick(); tx_accept = 0;
    chk("R12", "empty after accept", tx_empty, 1);
    bus_wdata = 8'hC3; bus_wr = 1; tx_accept = 1; tick();
    bus_wr = 0; tx_accept = 0;
    chk("R12", "write wins", tx_empty, 0);
    chk("R11", "tx_data C3", tx_data, 8'hC3);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_clean();
    t_short();
    t_errors();
    t_break();
    t_overrun();
    t_collide();
    t_tx();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule